// File: doc/BRIEF.md
# Identification Page Lock Controller

This block owns a single extra page of storage, 256 bytes by default, that sits beside a serial memory's main array. A shared I2C byte-level front end hands it bus events: Start, Stop, each byte received from the master, and each byte the block has transmitted together with the master's acknowledge. The block decodes commands that carry the device-type nibble 1011. It stages page-write data, answers ACK or NACK for every received byte, and supplies read data. It also keeps a one-way lock bit that stands in for a nonvolatile fuse.

One device-type code covers several operations. With address bit A10 clear, the command is a page write, or a lock-status probe when it is cut short. With A10 set, it is a lock request, and the request is honoured only when bit 1 of its data byte is set. A device select with RW=1 streams page bytes out from the current offset. Staged write data reaches the page store only on the Stop that closes the command, so a Start that arrives first discards it. Once the lock is set, every later page-write data byte is refused. Only a test-only clear input brings the page back to the unlocked, erased state.

Top module: `idp_lock_ctrl`

## Requirements
- R1: After the test clear (`fuse_clr_n` low) and reset, `page_locked` is 0, `resp_vld` is 0, and every page byte reads back as 8'hFF.
- R2: A device-select byte whose bits 7:4 are 4'b1011 is ACKed. Bit 0 of that byte is RW, where 0 means write and 1 means read. Any other nibble is NACKed, and every further byte up to the next Start is NACKed.
- R3: In a write command, A10 is bit 2 of the first address byte and the other bits of that byte are ignored. When A10 is 0, the second address byte sets the page offset. Each data byte is then ACKed and stored at the offset, and the offset advances. The page changes only at the Stop that follows.
- R4: The page offset wraps modulo 256 for both writes and reads. A byte after offset 8'hFF goes to offset 8'h00.
- R5: A Start that arrives before the Stop discards all staged data, so the page is unchanged. This is the lock-status probe.
- R6: A lock command has A10=1 and a data byte with bit 1 set. Its first data byte is ACKed while the page is unlocked, and `page_locked` rises at the following Stop, not before.
- R7: A lock data byte with bit 1 clear is NACKed and leaves the page unlocked.
- R8: While locked, page-write data bytes are NACKed and the page contents stay as they were.
- R9: A lock request sent while the page is already locked is NACKed, and the lock stays set.
- R10: Reads stream bytes from the current offset, which a write header may set just before a repeated Start. Each byte the master ACKs advances the offset, and a master NACK ends the stream. Reads work whether the page is locked or unlocked.
- R11: `rst_n` does not clear the lock or the page; only `fuse_clr_n` does.
- R12: Every received byte gets exactly one response, with `resp_vld` high in the clock cycle after `rx_vld`, and `resp_vld` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the command logic |
| fuse_clr_n | input | 1 | Active-low test-only clear of the lock and page (erased to FF) |
| bus_start | input | 1 | One-cycle pulse: Start or repeated Start seen |
| bus_stop | input | 1 | One-cycle pulse: Stop seen |
| rx_vld | input | 1 | One-cycle pulse: a byte from the master is in rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_done | input | 1 | One-cycle pulse: tx_byte was shifted out |
| tx_mack | input | 1 | Master acknowledge for the byte just sent (1 = ACK) |
| resp_vld | output | 1 | Response for the last received byte is valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_byte | output | 8 | Page byte at the current offset, for transmission |
| page_locked | output | 1 | Lock fuse state |

## Verification
A single Stop can both close a lock command and end the cycle in which staged page bytes would be committed. The block must therefore keep the lock-set path and the commit path apart. The bench stages page data, cancels it with a Start, and then issues a lock command. It checks that `page_locked` stays low right after the lock byte is ACKed and rises only after the Stop. Later writes to the same offsets are refused and their data never lands, which is confirmed by reading those offsets back.

// File: rtl/idp_pkg.sv
package idp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_WDATA,
      ST_READ
   } idp_state_e;
endpackage

// File: rtl/idp_cmd_fsm.sv
module idp_cmd_fsm
   import idp_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 8,
   parameter logic [3:0] DEV_TYPE = 4'b1011,
   parameter int SEL_BIT   = 2,
   parameter int LOCK_BIT  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          rx_vld,
   input  logic [DW-1:0] rx_byte,
   input  logic          tx_done,
   input  logic          tx_mack,
   input  logic          locked,
   output logic          resp_vld,
   output logic          resp_ack,
   output logic [AW-1:0] ptr,
   output logic          stage_we,
   output logic          stage_clr,
   output logic          commit,
   output logic          lock_set
);
   idp_state_e st;
   logic       is_lock;
   logic       first_data;
   logic       lock_req;
   logic       rx_take;
   logic       ack_now;
   logic       lock_ok;

   assign rx_take   = rx_vld && !bus_start && !bus_stop;
   assign stage_clr = bus_start || bus_stop;
   assign commit    = bus_stop && (st == ST_WDATA) && !is_lock;
   assign lock_set  = bus_stop && lock_req;
   assign stage_we  = rx_take && (st == ST_WDATA) && !is_lock && !locked;
   assign lock_ok   = first_data && !locked && rx_byte[LOCK_BIT];

   always_comb begin
      ack_now = 1'b0;
      unique case (st)
         ST_DEVSEL:  ack_now = (rx_byte[DW-1:DW-4] == DEV_TYPE);
         ST_ADDR_HI: ack_now = 1'b1;
         ST_ADDR_LO: ack_now = 1'b1;
         ST_WDATA:   ack_now = is_lock ? lock_ok : !locked;
         default:    ack_now = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         is_lock    <= 1'b0;
         first_data <= 1'b0;
         lock_req   <= 1'b0;
         ptr        <= '0;
         resp_vld   <= 1'b0;
         resp_ack   <= 1'b0;
      end else begin
         resp_vld <= rx_vld;
         resp_ack <= rx_take && ack_now;
         if (bus_start) begin
            st       <= ST_DEVSEL;
            lock_req <= 1'b0;
         end else if (bus_stop) begin
            st       <= ST_IDLE;
            lock_req <= 1'b0;
         end else if (rx_take) begin
            unique case (st)
               ST_DEVSEL: begin
                  if (!ack_now)       st <= ST_IDLE;
                  else if (rx_byte[0]) st <= ST_READ;
                  else                st <= ST_ADDR_HI;
               end
               ST_ADDR_HI: begin
                  is_lock <= rx_byte[SEL_BIT];
                  st      <= ST_ADDR_LO;
               end
               ST_ADDR_LO: begin
                  ptr        <= rx_byte[AW-1:0];
                  first_data <= 1'b1;
                  st         <= ST_WDATA;
               end
               ST_WDATA: begin
                  first_data <= 1'b0;
                  if (is_lock) lock_req <= lock_req || lock_ok;
                  else if (!locked) ptr <= ptr + 1'b1;
               end
               default: ;
            endcase
         end else if (tx_done && st == ST_READ) begin
            ptr <= ptr + 1'b1;
            if (!tx_mack) st <= ST_IDLE;
         end
      end
   end
endmodule

// File: rtl/idp_stage.sv
module idp_stage #(
   parameter int DW = 8,
   parameter int AW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       we,
   input  logic [AW-1:0]              waddr,
   input  logic [DW-1:0]              wdata,
   output logic [DEPTH-1:0]           pend_v,
   output logic [DEPTH-1:0][DW-1:0]   pend_d
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_v <= '0;
      else if (clr) pend_v <= '0;
      else if (we)  pend_v[waddr] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) pend_d[waddr] <= wdata;
   end
endmodule

// File: rtl/idp_store.sv
module idp_store #(
   parameter int DW = 8,
   parameter int AW = 8,
   parameter logic [7:0] ERASED = 8'hFF,
   localparam int DEPTH = 1 << AW
) (
   input  logic                     clk,
   input  logic                     fuse_clr_n,
   input  logic                     commit,
   input  logic [DEPTH-1:0]         pend_v,
   input  logic [DEPTH-1:0][DW-1:0] pend_d,
   input  logic                     lock_set,
   input  logic [AW-1:0]            raddr,
   output logic [DW-1:0]            rdata,
   output logic                     locked
);
   logic [DEPTH-1:0][DW-1:0] mem;

   always_ff @(posedge clk or negedge fuse_clr_n) begin
      if (!fuse_clr_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(ERASED);
      end else if (commit) begin
         for (int i = 0; i < DEPTH; i++)
            if (pend_v[i]) mem[i] <= pend_d[i];
      end
   end

   always_ff @(posedge clk or negedge fuse_clr_n) begin
      if (!fuse_clr_n)   locked <= 1'b0;
      else if (lock_set) locked <= 1'b1;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/idp_lock_ctrl.sv
module idp_lock_ctrl #(
   parameter int DW       = 8,
   parameter int AW       = 8,
   parameter logic [3:0] DEV_TYPE = 4'b1011,
   parameter int SEL_BIT  = 2,
   parameter int LOCK_BIT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fuse_clr_n,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          rx_vld,
   input  logic [7:0]    rx_byte,
   input  logic          tx_done,
   input  logic          tx_mack,
   output logic          resp_vld,
   output logic          resp_ack,
   output logic [7:0]    tx_byte,
   output logic          page_locked
);
   localparam int DEPTH = 1 << AW;

   if (DW != 8)                      $error("idp_lock_ctrl: DW must be 8");
   if (AW < 1 || AW > 8)             $error("idp_lock_ctrl: AW out of range");
   if (SEL_BIT < 0 || SEL_BIT >= DW) $error("idp_lock_ctrl: SEL_BIT out of range");
   if (LOCK_BIT < 1 || LOCK_BIT >= DW) $error("idp_lock_ctrl: LOCK_BIT out of range");

   logic [AW-1:0]            ptr;
   logic                     stage_we, stage_clr, commit, lock_set;
   logic [DEPTH-1:0]         pend_v;
   logic [DEPTH-1:0][DW-1:0] pend_d;

   idp_cmd_fsm #(.DW(DW), .AW(AW), .DEV_TYPE(DEV_TYPE), .SEL_BIT(SEL_BIT),
                 .LOCK_BIT(LOCK_BIT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_vld(rx_vld), .rx_byte(rx_byte), .tx_done(tx_done), .tx_mack(tx_mack),
      .locked(page_locked), .resp_vld(resp_vld), .resp_ack(resp_ack),
      .ptr(ptr), .stage_we(stage_we), .stage_clr(stage_clr),
      .commit(commit), .lock_set(lock_set)
   );

   idp_stage #(.DW(DW), .AW(AW)) u_stage (
      .clk(clk), .rst_n(rst_n), .clr(stage_clr), .we(stage_we),
      .waddr(ptr), .wdata(rx_byte), .pend_v(pend_v), .pend_d(pend_d)
   );

   idp_store #(.DW(DW), .AW(AW)) u_store (
      .clk(clk), .fuse_clr_n(fuse_clr_n), .commit(commit),
      .pend_v(pend_v), .pend_d(pend_d), .lock_set(lock_set),
      .raddr(ptr), .rdata(tx_byte), .locked(page_locked)
   );
endmodule

// File: rtl/idp_lock_ctrl_chk.sv
module idp_lock_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic fuse_clr_n,
   input logic bus_stop,
   input logic rx_vld,
   input logic resp_vld,
   input logic page_locked,
   input logic stage_we
);
   // R11
   lock_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_clr_n)
      page_locked |=> page_locked);
   // R6
   lock_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_clr_n)
      $rose(page_locked) |-> $past(bus_stop));
   // R12
   resp_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_clr_n)
      rx_vld |=> resp_vld);
   // R12
   no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_clr_n)
      !rx_vld |=> !resp_vld);
   // R8
   no_stage_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_clr_n)
      page_locked |-> !stage_we);
endmodule

bind idp_lock_ctrl idp_lock_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fuse_clr_n(fuse_clr_n), .bus_stop(bus_stop),
   .rx_vld(rx_vld), .resp_vld(resp_vld), .page_locked(page_locked),
   .stage_we(stage_we)
);

// File: tb/idp_lock_ctrl_test.sv
module idp_lock_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0, fuse_clr_n = 1'b0;
   logic bus_start = 0, bus_stop = 0, rx_vld = 0, tx_done = 0, tx_mack = 0;
   logic [7:0] rx_byte = '0;
   logic resp_vld, resp_ack, page_locked;
   logic [7:0] tx_byte;

   int checks = 0, errors = 0;
   bit   exp_ack_q[$];
   string exp_tag_q[$];

   always #4 clk = ~clk;

   idp_lock_ctrl uut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected responses (R12)
   always @(negedge clk) begin
      if (rst_n && resp_vld) begin
         if (exp_ack_q.size() == 0) chk(0, "R12 stray response", 1, 0);
         else begin
            automatic bit e = exp_ack_q.pop_front();
            automatic string t = exp_tag_q.pop_front();
            chk(resp_ack == e, t, resp_ack, e);
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
   endtask
   task automatic send(input logic [7:0] b, input bit ack, input string tag);
      exp_ack_q.push_back(ack); exp_tag_q.push_back(tag);
      @(negedge clk); rx_byte = b; rx_vld = 1;
      @(negedge clk); rx_vld = 0;
   endtask
   task automatic header(input logic [7:0] hi, input logic [7:0] lo, input string tag);
      pulse_start();
      send(8'hB6, 1, tag);
      send(hi, 1, tag);
      send(lo, 1, tag);
   endtask
   task automatic read_seq(input logic [7:0] off, input logic [7:0] exp[$], input string tag);
      header(8'hF3, off, tag);
      pulse_start();
      send(8'hB7, 1, tag);
      @(negedge clk);
      foreach (exp[i]) begin
         chk(tx_byte == exp[i], tag, tx_byte, exp[i]);
         tx_mack = (i != exp.size() - 1);
         tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
      end
      pulse_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      fuse_clr_n = 1; rst_n = 1;
      @(negedge clk);
      // R1
      chk(page_locked == 0, "R1 lock after clear", page_locked, 0);
      chk(resp_vld == 0, "R1 resp idle", resp_vld, 0);
      read_seq(8'h00, '{8'hFF, 8'hFF}, "R1 erased read");

      // R3 write with ignored upper bits, then R10 read back
      header(8'hFB, 8'h10, "R3 header");
      send(8'hA1, 1, "R3 data"); send(8'hA2, 1, "R3 data"); send(8'hA3, 1, "R3 data");
      pulse_stop();
      read_seq(8'h10, '{8'hA1, 8'hA2, 8'hA3}, "R10 read back");

      // R4 wrap
      header(8'h00, 8'hFE, "R4 header");
      send(8'h5A, 1, "R4 data"); send(8'h5B, 1, "R4 data"); send(8'h5C, 1, "R4 data");
      pulse_stop();
      read_seq(8'hFE, '{8'h5A, 8'h5B, 8'h5C}, "R4 wrap read");

      // R2 foreign device type
      pulse_start();
      send(8'hA0, 0, "R2 foreign devsel");
      send(8'h00, 0, "R2 following byte");
      send(8'h33, 0, "R2 following byte");
      pulse_stop();
      read_seq(8'h00, '{8'h5C}, "R2 page untouched");

      // R5 probe aborted by Start
      header(8'h00, 8'h20, "R5 header");
      send(8'h77, 1, "R5 probe ack unlocked");
      pulse_start(); pulse_stop();
      read_seq(8'h20, '{8'hFF}, "R5 discarded");

      // R7 lock byte without bit 1
      header(8'h04, 8'h00, "R7 header");
      send(8'hFD, 0, "R7 lock nack");
      pulse_stop();
      @(negedge clk);
      chk(page_locked == 0, "R7 still unlocked", page_locked, 0);

      // R6 lock
      header(8'h04, 8'h00, "R6 header");
      send(8'h02, 1, "R6 lock ack");
      @(negedge clk);
      chk(page_locked == 0, "R6 not before stop", page_locked, 0);
      pulse_stop();
      chk(page_locked == 1, "R6 locked after stop", page_locked, 1);

      // R8 write while locked
      header(8'h00, 8'h10, "R8 header");
      send(8'h99, 0, "R8 data nack"); send(8'h98, 0, "R8 data nack");
      pulse_stop();
      read_seq(8'h10, '{8'hA1, 8'hA2}, "R8 page unchanged");

      // R9 lock again
      header(8'h04, 8'h00, "R9 header");
      send(8'h02, 0, "R9 relock nack");
      pulse_stop();
      @(negedge clk);
      chk(page_locked == 1, "R9 lock kept", page_locked, 1);

      // R11 reset keeps lock; test clear erases
      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      chk(page_locked == 1, "R11 lock survives rst_n", page_locked, 1);
      read_seq(8'h11, '{8'hA2}, "R11 page survives rst_n");
      fuse_clr_n = 0; @(negedge clk); fuse_clr_n = 1; @(negedge clk);
      chk(page_locked == 0, "R11 cleared by fuse_clr_n", page_locked, 0);
      read_seq(8'h11, '{8'hFF}, "R11 erased by fuse_clr_n");

      repeat (3) @(negedge clk);
      chk(exp_ack_q.size() == 0, "R12 all responses seen", exp_ack_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule